// File: doc/BRIEF.md
# Faulting Instruction Exception Entry Sequencer

This block sits between the instruction decoder and the execute stage. Each decoded instruction arrives with a kind code, a privileged flag, its own address and the current status register. The block decides whether the instruction may run. If the kind code marks an illegal or unimplemented instruction, the block traps. It also traps when a privileged instruction, or a coprocessor's privilege-check request, shows up while the processor is in user mode. A trapping instruction never executes.

On a trap the block latches the status register and the instruction address. It stalls the front end and writes a four-word frame downward onto the supervisor stack through a 16-bit word-write port. It then reads the handler address from the vector table and hands the front end three values: the new program counter, the new status register with supervisor set and tracing off, and the new stack pointer.

Top module: `fault_entry_unit`

## Requirements
- R1: When `insn_valid` is high and no fault applies, the block writes nothing and `busy` stays low. When a fault applies, `busy` is high for exactly six cycles, starting the cycle after the instruction is accepted. `busy` stays high through the cycle in which `pc_load` pulses.
- R2: `insn_kind` values 1, 2 and 3 select vector numbers 4, 10 and 11 respectively. Kind 0 is a normal instruction. These faults apply in either privilege mode.
- R3: User mode is status bit 13 low. If `insn_priv` is high in user mode, the block takes vector 8. If `insn_priv` is high in supervisor mode, there is no fault.
- R4: If `cp_priv_chk` is high in user mode, the block takes vector 8. In supervisor mode the request causes no fault.
- R5: An illegal or unimplemented kind wins over a privilege fault raised in the same cycle.
- R6: On `pc_load`, `sr_new` is the latched status register with bit 13 set and bits 15 and 14 cleared. The stacked status word is the unmodified original.
- R7: The frame holds four word writes, each to the stack pointer minus 2 before that write, starting from `ssp_in`. The words are written in this order: the format/offset word `{4'h0, vector*4}`, PC bits 15:0, PC bits 31:16, then the original status word.
- R8: The stacked PC is `insn_pc` of the faulting instruction itself.
- R9: The cycle after the last stack write, `vec_re` is high with `vec_addr = VEC_BASE + vector*4`. In the next cycle `pc_load` pulses with `pc_new` equal to `vec_rdata`, and `ssp_new` equal to `ssp_in - 8`.
- R10: `insn_valid` is ignored while `busy` is high. A fault presented then produces no extra writes, and the block is idle afterwards.
- R11: After reset, `busy`, `stk_we`, `vec_re` and `pc_load` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| insn_valid | input | 1 | a decoded instruction is presented |
| insn_kind | input | 2 | 0 normal, 1 illegal, 2 and 3 unimplemented classes |
| insn_priv | input | 1 | instruction is privileged |
| cp_priv_chk | input | 1 | coprocessor requests a privilege check |
| insn_pc | input | 32 | address of the instruction's first word |
| sr_in | input | 16 | current status register |
| ssp_in | input | 32 | current supervisor stack pointer |
| busy | output | 1 | exception entry in progress, front end stalls |
| stk_we | output | 1 | stack word write strobe |
| stk_addr | output | 32 | stack word address |
| stk_wdata | output | 16 | stack word data |
| vec_re | output | 1 | vector table read strobe |
| vec_addr | output | 32 | vector table entry address |
| vec_rdata | input | 32 | vector entry, valid the cycle after `vec_re` |
| pc_load | output | 1 | one-cycle pulse: load new PC, SR and SSP |
| pc_new | output | 32 | handler address |
| sr_new | output | 16 | status register for the handler |
| ssp_new | output | 32 | stack pointer after the frame |

## Verification
The decision logic is tried with every kind code in both privilege modes, with the privileged flag and the coprocessor request on their own, together, and combined with illegal kinds. The bench tells apart vector 8 from vectors 4/10/11, no fault from a fault, and which cause wins a collision. Status words with the trace bits set, and varied PC and stack values, separate the stacked original SR from the new SR. They also separate the PC's high and low halves and their order in the frame. A fault injected while busy shows whether the sequencer can be re-entered.

// File: rtl/fault_entry_unit.sv
module fault_entry_unit #(
  parameter logic [31:0] VEC_BASE = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_valid,
  input  logic [1:0]  insn_kind,
  input  logic        insn_priv,
  input  logic        cp_priv_chk,
  input  logic [31:0] insn_pc,
  input  logic [15:0] sr_in,
  input  logic [31:0] ssp_in,
  output logic        busy,
  output logic        stk_we,
  output logic [31:0] stk_addr,
  output logic [15:0] stk_wdata,
  output logic        vec_re,
  output logic [31:0] vec_addr,
  input  logic [31:0] vec_rdata,
  output logic        pc_load,
  output logic [31:0] pc_new,
  output logic [15:0] sr_new,
  output logic [31:0] ssp_new
);
  localparam int SBIT = 13;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FMT, ST_PCL, ST_PCH, ST_SR, ST_FETCH, ST_LOAD
  } st_t;

  st_t         st;
  logic [31:0] sp_q, pc_q;
  logic [15:0] sr_q;
  logic [7:0]  vec_q, vec_d;
  logic        user, fault;

  assign user  = !sr_in[SBIT];
  assign fault = insn_valid && (insn_kind != 2'd0 || (user && (insn_priv || cp_priv_chk)));

  always_comb
    case (insn_kind)
      2'd1:    vec_d = 8'd4;
      2'd2:    vec_d = 8'd10;
      2'd3:    vec_d = 8'd11;
      default: vec_d = 8'd8;
    endcase

  always_ff @(posedge clk)
    if (!rst_n) begin
      st    <= ST_IDLE;
      sp_q  <= '0;
      pc_q  <= '0;
      sr_q  <= '0;
      vec_q <= '0;
    end else begin
      case (st)
        ST_IDLE:
          if (fault) begin
            st    <= ST_FMT;
            sp_q  <= ssp_in;
            pc_q  <= insn_pc;
            sr_q  <= sr_in;
            vec_q <= vec_d;
          end
        ST_FMT:   begin st <= ST_PCL;   sp_q <= stk_addr; end
        ST_PCL:   begin st <= ST_PCH;   sp_q <= stk_addr; end
        ST_PCH:   begin st <= ST_SR;    sp_q <= stk_addr; end
        ST_SR:    begin st <= ST_FETCH; sp_q <= stk_addr; end
        ST_FETCH: st <= ST_LOAD;
        default:  st <= ST_IDLE;
      endcase
    end

  assign busy     = st != ST_IDLE;
  assign stk_we   = st == ST_FMT || st == ST_PCL || st == ST_PCH || st == ST_SR;
  assign stk_addr = sp_q - 32'd2;

  always_comb
    case (st)
      ST_FMT:  stk_wdata = {4'h0, 2'b00, vec_q, 2'b00};
      ST_PCL:  stk_wdata = pc_q[15:0];
      ST_PCH:  stk_wdata = pc_q[31:16];
      ST_SR:   stk_wdata = sr_q;
      default: stk_wdata = '0;
    endcase

  assign vec_re   = st == ST_FETCH;
  assign vec_addr = VEC_BASE + {22'd0, vec_q, 2'b00};
  assign pc_load  = st == ST_LOAD;
  assign pc_new   = pc_load ? vec_rdata : '0;
  assign sr_new   = {2'b00, 1'b1, sr_q[12:0]};
  assign ssp_new  = sp_q;

  // R1
  load_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> busy);

  // R1
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !stk_we && !vec_re && !pc_load);

  // R7
  sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we && $past(stk_we) |-> stk_addr == $past(stk_addr) - 32'd2);

  // R9
  fetch_then_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> $past(vec_re));

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stk_we, vec_re, pc_load}));

  // R10
  frame_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(vec_addr));
endmodule

// File: tb/test_fault_entry_unit.sv
module test_fault_entry_unit;
  logic        clk = 0, rst_n = 0;
  logic        insn_valid = 0, insn_priv = 0, cp_priv_chk = 0;
  logic [1:0]  insn_kind = 0;
  logic [31:0] insn_pc = 0, ssp_in = 0;
  logic [15:0] sr_in = 0;
  logic        busy, stk_we, vec_re, pc_load;
  logic [31:0] stk_addr, vec_addr, pc_new, ssp_new;
  logic [15:0] stk_wdata, sr_new;
  logic [31:0] vec_rdata = 0;

  always #10 clk = ~clk;

  fault_entry_unit #(.VEC_BASE(32'h0000_0400)) i_fault_entry_unit (
    .clk, .rst_n, .insn_valid, .insn_kind, .insn_priv, .cp_priv_chk,
    .insn_pc, .sr_in, .ssp_in, .busy, .stk_we, .stk_addr, .stk_wdata,
    .vec_re, .vec_addr, .vec_rdata, .pc_load, .pc_new, .sr_new, .ssp_new);

  always @(posedge clk) if (vec_re) vec_rdata <= 32'hC000_0000 + vec_addr;

  int nchk = 0, nfail = 0, nwr = 0;
  logic [31:0] wa [8];
  logic [15:0] wd [8];
  always @(posedge clk)
    if (rst_n && stk_we) begin
      if (nwr < 8) begin wa[nwr] = stk_addr; wd[nwr] = stk_wdata; end
      nwr = nwr + 1;
    end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {priv, kind, cp, sr, pc, fault, vec}
  localparam int NV = 12;
  localparam logic [60:0] VT [NV] = '{
    {1'b0, 2'd0, 1'b0, 16'h0000, 32'h0000_1000, 1'b0, 8'd0},
    {1'b1, 2'd0, 1'b0, 16'h0004, 32'h1234_5678, 1'b1, 8'd8},
    {1'b1, 2'd0, 1'b0, 16'h2700, 32'h0000_2000, 1'b0, 8'd0},
    {1'b0, 2'd1, 1'b0, 16'h2000, 32'hABCD_0010, 1'b1, 8'd4},
    {1'b0, 2'd2, 1'b0, 16'h0011, 32'h0001_0002, 1'b1, 8'd10},
    {1'b0, 2'd3, 1'b0, 16'hA300, 32'h8000_FFFE, 1'b1, 8'd11},
    {1'b1, 2'd1, 1'b0, 16'h0000, 32'h5555_AAAA, 1'b1, 8'd4},
    {1'b0, 2'd0, 1'b1, 16'h0008, 32'h0BAD_F00D, 1'b1, 8'd8},
    {1'b0, 2'd0, 1'b1, 16'h2010, 32'h0000_3000, 1'b0, 8'd0},
    {1'b1, 2'd0, 1'b0, 16'hC01F, 32'hFEDC_BA98, 1'b1, 8'd8},
    {1'b0, 2'd3, 1'b1, 16'h0000, 32'h0000_4000, 1'b1, 8'd11},
    {1'b1, 2'd2, 1'b1, 16'h4002, 32'h7777_0000, 1'b1, 8'd10}
  };

  task automatic run_case(logic pr, logic [1:0] kd, logic cp, logic [15:0] sr,
                          logic [31:0] pc, logic [31:0] sp, logic ef,
                          logic [7:0] ev, logic inject);
    int nb = 0, nl = 0;
    logic [31:0] gpc = 0, gsp = 0;
    logic [15:0] gsr = 0;
    @(negedge clk);
    nwr = 0;
    insn_priv = pr; insn_kind = kd; cp_priv_chk = cp; sr_in = sr;
    insn_pc = pc; ssp_in = sp; insn_valid = 1;
    @(negedge clk);
    insn_valid = 0;
    for (int i = 0; i < 10; i++) begin
      if (busy) nb++;
      if (pc_load) begin nl++; gpc = pc_new; gsr = sr_new; gsp = ssp_new; end
      if (inject) insn_valid = (i == 1);
      if (i == 1 && inject) begin insn_kind = 2'd3; insn_pc = 32'h9999_0000; end
      @(negedge clk);
    end
    insn_valid = 0;
    if (!ef) begin
      chk("R1 no-fault writes", nwr, 0);
      chk("R1 no-fault busy", nb, 0);
    end else begin
      chk("R1 busy cycles", nb, 6);
      chk("R10/R7 write count", nwr, 4);
      chk("R9 load pulses", nl, 1);
      chk("R7 fmt addr", wa[0], sp - 2);
      chk("R7 fmt word R2 R3 R4 R5", wd[0], {20'd0, ev, 2'b00});
      chk("R8 pc low", {wa[1], 16'd0, wd[1]}, {sp - 32'd4, 16'd0, pc[15:0]});
      chk("R8 pc high", {wa[2], 16'd0, wd[2]}, {sp - 32'd6, 16'd0, pc[31:16]});
      chk("R6 stacked sr", {wa[3], 16'd0, wd[3]}, {sp - 32'd8, 16'd0, sr});
      chk("R9 handler", gpc, 32'hC000_0000 + 32'h400 + {22'd0, ev, 2'b00});
      chk("R6 new sr", gsr, (sr | 16'h2000) & 16'h3FFF);
      chk("R9 ssp", gsp, sp - 32'd8);
    end
    chk("R10 idle after", busy, 0);
  endtask

  initial begin
    #(20 * 5000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11
    chk("R11 busy", busy, 0);
    chk("R11 stk_we", stk_we, 0);
    chk("R11 vec_re", vec_re, 0);
    chk("R11 pc_load", pc_load, 0);
    rst_n = 1;
    for (int v = 0; v < NV; v++)
      run_case(VT[v][60], VT[v][59:58], VT[v][57], VT[v][56:41], VT[v][40:9],
               32'h0000_2000 + 32'h100 * v, VT[v][8], VT[v][7:0], 1'b0);
    // R10 fault presented mid-entry is ignored
    run_case(1'b0, 2'd1, 1'b0, 16'h0000, 32'h0000_5000, 32'h0000_8000, 1'b1, 8'd4, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule